// File: doc/BRIEF.md
# Speculative Store Buffer

This block holds stores from the moment the front end allocates them until they are written to the data cache. A slot is reserved in program order when a store is allocated, and the allocating side learns the slot index. The address and data arrive later, when the store executes, and stores may execute in any order. A store stays speculative until the retire side graduates it. Only graduated stores may touch the cache, so a rollback can drop every store that has not retired and nothing outside the core ever sees them.

Graduated stores leave strictly oldest-first. For each one the buffer first asks for exclusive ownership of the target line and waits for a grant. It then offers the write on a valid/ready port. The oldest slot is released when that write is accepted. A flush drops every speculative slot and keeps the graduated ones, which still drain in order afterwards.

Back-pressure works as follows. Allocation is a valid/ready handshake in which `alloc_ready` is low while all slots are occupied or a flush is present. The cache write is valid/ready: once `wr_valid` rises, it and its address and data stay fixed until `wr_ready` is seen high at a clock edge. The execute fill, retire and flush inputs are plain pulses that are never stalled. The ownership request is held with a stable address until `own_gnt` is seen.

Top module: `spec_store_buffer`

## Requirements
- R1: After reset the buffer is empty: `alloc_ready`=1, `alloc_id`=0, `own_req`=0, `wr_valid`=0.
- R2: An allocation is taken on a clock edge where `alloc_valid` and `alloc_ready` are both high. It is given slot `alloc_id`, and successive allocations get consecutive indices modulo DEPTH. `alloc_ready` is low while DEPTH slots are occupied.
- R3: An execute pulse stores `exe_addr`/`exe_data` into slot `exe_id` and writes nothing to the cache. `own_req` and `wr_valid` stay low while no slot is graduated.
- R4: A retire pulse graduates the oldest speculative slot if that slot has been filled. A retire pulse is ignored when no speculative slot exists or the oldest one is not yet filled.
- R5: While the oldest slot is graduated and no write is pending, `own_req` is high with that slot's address. It stays high with a stable address until `own_gnt`. `wr_valid` rises only in the cycle after a grant.
- R6: The write carries the oldest slot's address and data. It is held stable until `wr_ready`, and the slot is freed on that handshake. There is at most one write per handshake, and writes leave in allocation order.
- R7: A flush discards all speculative slots and keeps graduated slots, which still drain. The next allocation gets the index just past the youngest graduated slot.
- R8: When retire and flush arrive in the same cycle, the retire is applied first, so the slot it graduates survives the flush.
- R9: An execute pulse naming a slot that is not currently speculative (graduated or unallocated) is ignored.
- R10: `alloc_ready` is low in a cycle where `flush` is high, so an allocation is never lost to a flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Allocation request |
| alloc_ready | output | 1 | Allocation can be taken |
| alloc_id | output | $clog2(DEPTH) | Slot given to the allocated store |
| exe_valid | input | 1 | Execute fill pulse |
| exe_id | input | $clog2(DEPTH) | Slot being filled |
| exe_addr | input | AW | Store address |
| exe_data | input | DW | Store data |
| ret_valid | input | 1 | Retire pulse for the oldest speculative store |
| flush | input | 1 | Discard speculative stores |
| own_req | output | 1 | Request exclusive ownership of the line |
| own_addr | output | AW | Address for the ownership request |
| own_gnt | input | 1 | Ownership granted |
| wr_valid | output | 1 | Cache write offered |
| wr_ready | input | 1 | Cache accepts the write |
| wr_addr | output | AW | Cache write address |
| wr_data | output | DW | Cache write data |

## Verification
The same-cycle collision that matters most is a retire arriving together with a flush. The bench provokes it on purpose, with a filled speculative slot at the graduation point and a younger speculative slot behind it. Its reference model applies the retire before rebuilding the tail, so the bench expects the retired store to be drained to the cache and the younger one never to appear. A long pseudo-random sweep also overlaps flushes with pending writes, allocations and fills, and it compares every output against the model in every cycle.

// File: rtl/sb_pkg.sv
package sb_pkg;
  typedef enum logic {
    DRN_IDLE  = 1'b0,
    DRN_WRITE = 1'b1
  } drain_state_e;
endpackage

// File: rtl/sb_ptr_ctrl.sv
// Head / graduation / tail pointers with one wrap bit each.
module sb_ptr_ctrl #(
  parameter int DEPTH = 8,
  localparam int IW = $clog2(DEPTH),
  localparam int PW = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_try,
  input  logic          pop,
  input  logic          ret_req,
  input  logic          grad_filled,
  input  logic          flush,
  output logic          alloc_rdy,
  output logic          push,
  output logic          ret_ok,
  output logic [IW-1:0] head_idx,
  output logic [IW-1:0] grad_idx,
  output logic [IW-1:0] tail_idx,
  output logic [PW-1:0] occ,
  output logic [PW-1:0] grad_cnt,
  output logic [PW-1:0] spec_cnt
);
  logic [PW-1:0] head_q, grad_q, tail_q, grad_n;

  assign head_idx = head_q[IW-1:0];
  assign grad_idx = grad_q[IW-1:0];
  assign tail_idx = tail_q[IW-1:0];

  always_comb begin
    occ       = tail_q - head_q;
    grad_cnt  = grad_q - head_q;
    spec_cnt  = tail_q - grad_q;
    alloc_rdy = (occ != PW'(DEPTH)) && !flush;
    push      = alloc_try && alloc_rdy;
    ret_ok    = ret_req && (spec_cnt != '0) && grad_filled;
    grad_n    = grad_q + PW'(ret_ok);
  end

  // retire is folded in before the flush rebuilds the tail
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      grad_q <= '0;
      tail_q <= '0;
    end else begin
      head_q <= head_q + PW'(pop);
      grad_q <= grad_n;
      tail_q <= flush ? grad_n : tail_q + PW'(push);
    end
  end

  p_occ_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= PW'(DEPTH));
  p_grad_inside_r4: assert property (@(posedge clk) disable iff (!rst_n)
    grad_cnt <= occ);
  p_pop_graduated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> grad_cnt != '0);
  p_flush_spares_grad_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !pop) |=> grad_cnt >= $past(grad_cnt));
endmodule

// File: rtl/sb_drain.sv
// Oldest-first drain: ownership request, then cache write handshake.
module sb_drain
  import sb_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          have_grad,
  input  logic [AW-1:0] head_addr,
  input  logic [DW-1:0] head_data,
  output logic          own_req,
  output logic [AW-1:0] own_addr,
  input  logic          own_gnt,
  output logic          wr_valid,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  input  logic          wr_ready,
  output logic          pop
);
  drain_state_e st_q;

  assign own_req  = (st_q == DRN_IDLE) && have_grad;
  assign own_addr = head_addr;
  assign wr_valid = (st_q == DRN_WRITE);
  assign wr_addr  = head_addr;
  assign wr_data  = head_data;
  assign pop      = wr_valid && wr_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= DRN_IDLE;
    else begin
      case (st_q)
        DRN_IDLE:  if (own_req && own_gnt) st_q <= DRN_WRITE;
        DRN_WRITE: if (wr_ready) st_q <= DRN_IDLE;
        default:   st_q <= DRN_IDLE;
      endcase
    end
  end

  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (own_req && !own_gnt) |=> (own_req && $stable(own_addr)));
  p_wr_after_gnt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid ##1 wr_valid |-> $past(own_req && own_gnt));
  p_wr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));
endmodule

// File: rtl/spec_store_buffer.sv
module spec_store_buffer
  import sb_pkg::*;
#(
  parameter int DEPTH = 8,   // power of two, at least 2
  parameter int AW    = 32,
  parameter int DW    = 32,
  localparam int IW   = $clog2(DEPTH),
  localparam int PW   = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_valid,
  output logic          alloc_ready,
  output logic [IW-1:0] alloc_id,
  input  logic          exe_valid,
  input  logic [IW-1:0] exe_id,
  input  logic [AW-1:0] exe_addr,
  input  logic [DW-1:0] exe_data,
  input  logic          ret_valid,
  input  logic          flush,
  output logic          own_req,
  output logic [AW-1:0] own_addr,
  input  logic          own_gnt,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);
  logic          push, pop, ret_ok, fill_hit;
  logic [IW-1:0] head_idx, grad_idx, tail_idx, fill_off;
  logic [PW-1:0] occ, grad_cnt, spec_cnt;
  logic [AW-1:0] addr_q [DEPTH];
  logic [DW-1:0] data_q [DEPTH];
  logic          filled_q [DEPTH];

  sb_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
    .clk(clk), .rst_n(rst_n), .alloc_try(alloc_valid), .pop(pop),
    .ret_req(ret_valid), .grad_filled(filled_q[grad_idx]), .flush(flush),
    .alloc_rdy(alloc_ready), .push(push), .ret_ok(ret_ok),
    .head_idx(head_idx), .grad_idx(grad_idx), .tail_idx(tail_idx),
    .occ(occ), .grad_cnt(grad_cnt), .spec_cnt(spec_cnt)
  );

  assign alloc_id = tail_idx;

  // a fill lands only inside the speculative window [grad, tail)
  assign fill_off = exe_id - grad_idx;
  assign fill_hit = exe_valid && ({1'b0, fill_off} < spec_cnt);

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) filled_q[i] <= 1'b0;
      else if (push && tail_idx == IW'(i)) filled_q[i] <= 1'b0;
      else if (fill_hit && exe_id == IW'(i)) filled_q[i] <= 1'b1;
    end
    always_ff @(posedge clk) begin
      if (fill_hit && exe_id == IW'(i)) begin
        addr_q[i] <= exe_addr;
        data_q[i] <= exe_data;
      end
    end
  end

  sb_drain #(.AW(AW), .DW(DW)) u_drain (
    .clk(clk), .rst_n(rst_n), .have_grad(grad_cnt != '0),
    .head_addr(addr_q[head_idx]), .head_data(data_q[head_idx]),
    .own_req(own_req), .own_addr(own_addr), .own_gnt(own_gnt),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_ready(wr_ready), .pop(pop)
  );

  p_head_filled_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (own_req || wr_valid) |-> filled_q[head_idx]);
  p_retire_filled_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ret_ok |-> filled_q[grad_idx]);
  p_flush_blocks_alloc_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !push);
endmodule

// File: tb/test_spec_store_buffer.sv
module test_spec_store_buffer;
  localparam int CLK_P = 10;
  localparam int D  = 4;
  localparam int IW = 2;
  localparam int AW = 8;
  localparam int DW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic alloc_valid = 0, exe_valid = 0, ret_valid = 0, flush = 0, own_gnt = 0, wr_ready = 0;
  logic [IW-1:0] exe_id = '0;
  logic [AW-1:0] exe_addr = '0;
  logic [DW-1:0] exe_data = '0;
  logic alloc_ready, own_req, wr_valid;
  logic [IW-1:0] alloc_id;
  logic [AW-1:0] own_addr, wr_addr;
  logic [DW-1:0] wr_data;

  spec_store_buffer #(.DEPTH(D), .AW(AW), .DW(DW)) i_spec_store_buffer (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
    .alloc_id(alloc_id), .exe_valid(exe_valid), .exe_id(exe_id), .exe_addr(exe_addr),
    .exe_data(exe_data), .ret_valid(ret_valid), .flush(flush), .own_req(own_req),
    .own_addr(own_addr), .own_gnt(own_gnt), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data)
  );

  always #(CLK_P/2) clk = ~clk;

  int total = 0, bad = 0;
  bit done = 0;
  string phase = "R1";
  // reference model: monotonic pointers, slot contents, drain state
  int mh = 0, mg = 0, mt = 0, ms = 0;
  int m_a [D], m_d [D], m_f [D];
  logic [31:0] rnd = 32'h1234_5678;

  task automatic chk(input string sig, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", phase, sig, act, exp);
    end
  endtask

  task automatic step(input bit a, input bit e, input int eid, input int ea, input int ed,
                      input bit r, input bit f, input bit g, input bit w);
    int occ, ng, sp, off;
    bit push, pop, rok, ehit;
    @(negedge clk);
    alloc_valid = a; exe_valid = e; exe_id = IW'(eid); exe_addr = AW'(ea);
    exe_data = DW'(ed); ret_valid = r; flush = f; own_gnt = g; wr_ready = w;
    #1;
    occ = mt - mh; ng = mg - mh; sp = mt - mg;
    chk("alloc_ready", int'(alloc_ready), int'(occ < D && !f));
    chk("alloc_id", int'(alloc_id), mt % D);
    chk("own_req", int'(own_req), int'(ms == 0 && ng > 0));
    if (ms == 0 && ng > 0) chk("own_addr", int'(own_addr), m_a[mh % D]);
    chk("wr_valid", int'(wr_valid), ms);
    if (ms == 1) begin
      chk("wr_addr", int'(wr_addr), m_a[mh % D]);
      chk("wr_data", int'(wr_data), m_d[mh % D]);
    end
    push = a && occ < D && !f;
    pop  = (ms == 1) && w;
    rok  = r && sp > 0 && m_f[mg % D] != 0;
    off  = (eid - mg) & (D - 1);
    ehit = e && off < sp;
    @(posedge clk);
    if (ehit) begin m_f[eid] = 1; m_a[eid] = ea & 8'hff; m_d[eid] = ed & 8'hff; end
    if (push) m_f[mt % D] = 0;
    mg = mg + int'(rok);
    mt = f ? mg : mt + int'(push);
    mh = mh + int'(pop);
    if (ms == 0 && ng > 0 && g) ms = 1;
    else if (ms == 1 && w) ms = 0;
  endtask

  task automatic idle(input bit g, input bit w, input int n);
    for (int k = 0; k < n; k++) step(0, 0, 0, 0, 0, 0, 0, g, w);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog R6 act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < D; i++) begin m_a[i] = 0; m_d[i] = 0; m_f[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    phase = "R1 reset"; idle(0, 0, 1);
    phase = "R2 fill to full";
    for (int k = 0; k < 6; k++) step(1, 0, 0, 0, 0, 0, 0, 0, 0);
    phase = "R3 out-of-order fills";
    step(0, 1, 2, 8'h12, 8'hA2, 0, 0, 0, 0);
    step(0, 1, 0, 8'h10, 8'hA0, 0, 0, 0, 0);
    step(0, 1, 3, 8'h13, 8'hA3, 0, 0, 0, 0);
    step(0, 1, 1, 8'h11, 8'hA1, 0, 0, 0, 0);
    idle(1, 1, 3);
    phase = "R4 retire two";
    step(0, 0, 0, 0, 0, 1, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1, 0, 0, 0);
    phase = "R5 grant wait"; idle(0, 0, 2);
    step(0, 0, 0, 0, 0, 0, 0, 1, 0);
    phase = "R6 write stall"; idle(0, 0, 2);
    idle(1, 1, 5);
    phase = "R7 flush keeps graduated";
    step(0, 0, 0, 0, 0, 1, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 1, 0, 0);
    idle(0, 0, 1);
    step(1, 0, 0, 0, 0, 0, 0, 0, 0);
    idle(1, 1, 4);
    phase = "R4 unfilled retire ignored";
    step(0, 0, 0, 0, 0, 1, 0, 0, 0);
    idle(1, 1, 1);
    step(0, 1, 0, 8'h40, 8'hB0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1, 0, 0, 0);
    idle(1, 1, 4);
    phase = "R8 retire with flush";
    step(1, 0, 0, 0, 0, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0, 0, 0, 0);
    step(0, 1, 1, 8'h51, 8'hC1, 0, 0, 0, 0);
    step(0, 1, 2, 8'h52, 8'hC2, 0, 0, 0, 0);
    step(0, 1, 3, 8'h53, 8'hC3, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1, 1, 0, 0);
    idle(1, 1, 6);
    phase = "R9 fill outside window";
    step(1, 0, 0, 0, 0, 0, 0, 0, 0);
    step(0, 1, mt % D, 8'h61, 8'hD1, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1, 0, 0, 0);
    step(0, 1, (mt + D - 1) % D, 8'hEE, 8'hEE, 0, 0, 0, 0);
    step(0, 1, (mt + 1) % D, 8'hEF, 8'hEF, 0, 0, 0, 0);
    idle(0, 0, 2);
    idle(1, 1, 4);
    phase = "R10 flush with alloc";
    step(1, 0, 0, 0, 0, 0, 1, 0, 0);
    step(1, 0, 0, 0, 0, 0, 0, 0, 0);
    phase = "R6 R8 sweep";
    for (int k = 0; k < 6000; k++) begin
      rnd = rnd ^ (rnd << 13); rnd = rnd ^ (rnd >> 17); rnd = rnd ^ (rnd << 5);
      step(rnd[0], rnd[1], int'(rnd[3:2]), int'(rnd[15:8]), int'(rnd[23:16]),
           rnd[4] | rnd[5], rnd[29:26] == 4'd0, rnd[6], rnd[7] | rnd[30]);
    end
    phase = "R6 final drain"; idle(1, 1, 20);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule